// File: doc/BRIEF.md
# Local Interrupt Acceptance and Priority Unit

This unit sits between the interrupt message fabric and one processor core. Each incoming message carries a vector, a three-bit delivery mode and a trigger kind (level or edge). Ordinary requests are stored as one bit per vector in a request set. A matching in-service set records which vectors the core is handling, and a trigger set records the trigger kind of each request. The special kinds (system management, non-maskable, initialisation, startup and external) each have a single pending flag and a captured vector instead.

Every cycle the unit tells the core whether something is deliverable. It takes into account the core's interrupt-enable input and an 8-bit task priority value. It also presents the kind and vector that an acknowledge would take. An acknowledge pulse commits that choice. An end-of-interrupt pulse retires the highest in-service vector. All state is held in registers, and every output is derived combinationally from that state. A stimulus clocked in at one edge is therefore visible on the outputs right after that edge. The reset input is asynchronous and active low, and its release is expected to be synchronised outside the unit.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, irq_pending is 0, sel_kind is 0 (none), sel_vector, top_req_vec, top_svc_vec and tpr_value are 0, and every request, in-service and pending flag is clear.
- R2: A message with delivery mode 0 (fixed) or 1 (lowest priority) sets the request bit of its vector. The trigger bit of that vector is written (1 = level, 0 = edge) only when the request bit was clear beforehand. top_req_level shows the trigger bit of the highest request, and top_req_vec shows the highest set request bit, or 0 when the request set is empty.
- R3: Modes 2 (system management), 4 (non-maskable), 5 (init) and 7 (external) each set their own pending flag and capture the message vector, but only when that flag is clear. A message of mode 3 changes no state.
- R4: A startup message (mode 6) is accepted only if no startup is pending and the core has not been started since the last acknowledged init. Acknowledging init clears the started state, and acknowledging startup sets it.
- R5: When any system management, non-maskable, init or startup flag is pending, irq_pending is 1 whatever the value of core_ie.
- R6: With core_ie = 1, irq_pending is also 1 when an external interrupt is pending. It is also 1 when top_req_vec > top_svc_vec and bits 7:4 of top_req_vec exceed bits 7:4 of tpr_value. With core_ie = 0 and no flag of R5 pending, irq_pending is 0.
- R7: The selection follows this priority: system management (sel_kind 1), non-maskable (2), init (3), startup (4), external (5), fixed (6). sel_kind 0 means nothing is deliverable. sel_vector is the captured vector of the chosen kind, or top_req_vec for a fixed interrupt.
- R8: An ack while irq_pending is 1 clears only the pending flag of the selected kind. An ack while irq_pending is 0 changes no state.
- R9: Acknowledging a fixed interrupt clears its vector's request bit and sets its in-service bit. top_req_vec and top_svc_vec are updated in the next cycle.
- R10: An eoi pulse clears the highest set in-service bit, and top_svc_vec falls to the next one, or to 0.
- R11: A tpr_we pulse loads tpr_wdata into tpr_value. The priority gate of R6 then uses its upper four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming interrupt message strobe |
| msg_mode | input | 3 | Delivery mode of the message |
| msg_vector | input | 8 | Vector of the message |
| msg_level | input | 1 | Trigger kind: 1 level, 0 edge |
| core_ie | input | 1 | Core interrupt-enable flag |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| eoi | input | 1 | End-of-interrupt strobe |
| ack | input | 1 | Core acknowledge strobe |
| irq_pending | output | 1 | An interrupt is deliverable |
| sel_kind | output | 3 | Kind an acknowledge would take |
| sel_vector | output | 8 | Vector an acknowledge would take |
| top_req_level | output | 1 | Trigger bit of the highest request |
| top_req_vec | output | 8 | Highest requested vector |
| top_svc_vec | output | 8 | Highest in-service vector |
| tpr_value | output | 8 | Current task priority |

## Verification
Each strobe (message, ack, eoi, task priority write) is registered once, and every output is combinational from the registers. The effect of a strobe is therefore due in the first cycle after the edge that samples it. A change on core_ie reaches irq_pending and the selection within the same cycle. The bench drives each strobe for exactly one cycle from a falling edge and removes it at the next falling edge. It reads the outputs at that falling edge, after the capturing rising edge has passed. For core_ie it samples shortly after the change. No result is read at an active edge.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWPRI  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSVD    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXTINT  = 3'd7
  } dmode_e;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_SMI     = 3'd1,
    K_NMI     = 3'd2,
    K_INIT    = 3'd3,
    K_STARTUP = 3'd4,
    K_EXT     = 3'd5,
    K_FIXED   = 3'd6
  } kind_e;

  // Slots of the special-flag bank, in acknowledge priority order.
  localparam int unsigned NSPEC   = 5;
  localparam int unsigned SP_SMI  = 0;
  localparam int unsigned SP_NMI  = 1;
  localparam int unsigned SP_INIT = 2;
  localparam int unsigned SP_SIPI = 3;
  localparam int unsigned SP_EXT  = 4;

endpackage

// File: rtl/irq_msb_find.sv
// Highest-set-bit search, split into groups so the depth is two short scans.
module irq_msb_find #(
  parameter int unsigned WIDTH = 256,
  parameter int unsigned GROUP = 16
) (
  input  logic [WIDTH-1:0]         bits_i,
  output logic [$clog2(WIDTH)-1:0] idx_o
);
  localparam int unsigned IDXW  = $clog2(WIDTH);
  localparam int unsigned NGRP  = WIDTH / GROUP;
  localparam int unsigned GIDXW = $clog2(GROUP);

  logic [NGRP-1:0]  grp_any;
  logic [GIDXW-1:0] grp_idx [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GIDXW-1:0] idx_l;
    always_comb begin
      idx_l = '0;
      for (int b = 0; b < GROUP; b++) begin
        if (bits_i[g*GROUP + b]) idx_l = GIDXW'(b);
      end
    end
    assign grp_any[g] = |bits_i[g*GROUP +: GROUP];
    assign grp_idx[g] = idx_l;
  end

  always_comb begin
    idx_o = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) idx_o = IDXW'(g * GROUP) + IDXW'(grp_idx[g]);
    end
  end

endmodule

// File: rtl/irq_vec_store.sv
// Request, in-service and trigger bit sets with their highest-bit searches.
module irq_vec_store #(
  parameter int unsigned NVEC  = 256,
  parameter int unsigned GROUP = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  logic [$clog2(NVEC)-1:0] set_idx,
  input  logic                    set_level,
  input  logic                    move_en,
  input  logic                    retire_en,
  output logic [$clog2(NVEC)-1:0] hi_req,
  output logic [$clog2(NVEC)-1:0] hi_svc,
  output logic                    hi_req_level
);
  logic [NVEC-1:0] req_q, req_n;
  logic [NVEC-1:0] svc_q, svc_n;
  logic [NVEC-1:0] tmr_q, tmr_n;
  logic            upd_en;

  irq_msb_find #(.WIDTH(NVEC), .GROUP(GROUP)) u_req_find (
    .bits_i (req_q),
    .idx_o  (hi_req)
  );

  irq_msb_find #(.WIDTH(NVEC), .GROUP(GROUP)) u_svc_find (
    .bits_i (svc_q),
    .idx_o  (hi_svc)
  );

  assign hi_req_level = tmr_q[hi_req];
  assign upd_en       = set_en | move_en | retire_en;

  always_comb begin
    req_n = req_q;
    svc_n = svc_q;
    tmr_n = tmr_q;
    if (retire_en) svc_n[hi_svc] = 1'b0;
    if (move_en) begin
      req_n[hi_req] = 1'b0;
      svc_n[hi_req] = 1'b1;
    end
    if (set_en) begin
      req_n[set_idx] = 1'b1;
      if (!req_q[set_idx]) tmr_n[set_idx] = set_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      svc_q <= '0;
      tmr_q <= '0;
    end else if (upd_en) begin
      req_q <= req_n;
      svc_q <= svc_n;
      tmr_q <= tmr_n;
    end
  end

  // R9
  move_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_en && !(set_en && set_idx == hi_req)) |=>
      (!req_q[$past(hi_req)] && svc_q[$past(hi_req)]));

  // R10
  retire_clears_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_en && !(move_en && hi_req == hi_svc)) |=> !svc_q[$past(hi_svc)]);

  // R2
  repeat_keeps_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && req_q[set_idx]) |=> (tmr_q[$past(set_idx)] == $past(tmr_q[set_idx])));

endmodule

// File: rtl/irq_special_pend.sv
// Single-entry pending flags with captured vectors for the special kinds.
module irq_special_pend
  import irq_accept_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        msg_valid,
  input  logic [2:0]                  msg_mode,
  input  logic [VEC_W-1:0]            msg_vector,
  input  logic [NSPEC-1:0]            clr_i,
  output logic [NSPEC-1:0]            pend_o,
  output logic [NSPEC-1:0][VEC_W-1:0] vec_o
);
  localparam dmode_e KMODE [NSPEC] = '{DM_SMI, DM_NMI, DM_INIT, DM_STARTUP, DM_EXTINT};

  logic started_q, started_n, started_en;

  for (genvar k = 0; k < NSPEC; k++) begin : g_slot
    logic             pend_q, pend_n, take;
    logic [VEC_W-1:0] vec_q;
    logic             gate_ok;

    if (k == SP_SIPI) begin : g_sipi
      assign gate_ok = !started_q;
    end else begin : g_plain
      assign gate_ok = 1'b1;
    end

    assign take = msg_valid && (msg_mode == KMODE[k]) && !pend_q && gate_ok;

    always_comb begin
      pend_n = pend_q;
      if (clr_i[k]) pend_n = 1'b0;
      if (take)     pend_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else if (take || clr_i[k]) begin
        pend_q <= pend_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q <= '0;
      end else if (take) begin
        vec_q <= msg_vector;
      end
    end

    assign pend_o[k] = pend_q;
    assign vec_o[k]  = vec_q;

    // R8
    ack_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && pend_q) |=> !pend_q);
  end

  always_comb begin
    started_n  = started_q;
    started_en = clr_i[SP_INIT] | clr_i[SP_SIPI];
    if (clr_i[SP_SIPI]) started_n = 1'b1;
    if (clr_i[SP_INIT]) started_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
    end else if (started_en) begin
      started_q <= started_n;
    end
  end

  // R4
  init_ack_unstarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[SP_INIT] |=> !started_q);

  // R4
  started_blocks_sipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !g_slot[SP_SIPI].pend_q) |=> !g_slot[SP_SIPI].pend_q);

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned GROUP  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [2:0]       msg_mode,
  input  logic [VEC_W-1:0] msg_vector,
  input  logic             msg_level,
  input  logic             core_ie,
  input  logic             tpr_we,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             eoi,
  input  logic             ack,
  output logic             irq_pending,
  output logic [2:0]       sel_kind,
  output logic [VEC_W-1:0] sel_vector,
  output logic             top_req_level,
  output logic [VEC_W-1:0] top_req_vec,
  output logic [VEC_W-1:0] top_svc_vec,
  output logic [VEC_W-1:0] tpr_value
);
  localparam int unsigned NVEC = 1 << VEC_W;

  logic [VEC_W-1:0]            tpr_q;
  logic [VEC_W-1:0]            hi_req, hi_svc;
  logic [NSPEC-1:0]            pend;
  logic [NSPEC-1:0][VEC_W-1:0] pvec;
  logic [NSPEC-1:0]            pick, clr;
  logic                        fixed_msg, fixed_ok, spec_any, take_ack, move_en;
  kind_e                       kind;

  assign fixed_msg = msg_valid && (msg_mode == DM_FIXED || msg_mode == DM_LOWPRI);

  irq_vec_store #(.NVEC(NVEC), .GROUP(GROUP)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_en       (fixed_msg),
    .set_idx      (msg_vector),
    .set_level    (msg_level),
    .move_en      (move_en),
    .retire_en    (eoi),
    .hi_req       (hi_req),
    .hi_svc       (hi_svc),
    .hi_req_level (top_req_level)
  );

  irq_special_pend #(.VEC_W(VEC_W)) u_spec (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_mode   (msg_mode),
    .msg_vector (msg_vector),
    .clr_i      (clr),
    .pend_o     (pend),
    .vec_o      (pvec)
  );

  // Task priority register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q <= '0;
    end else if (tpr_we) begin
      tpr_q <= tpr_wdata;
    end
  end

  assign spec_any = pend[SP_SMI] | pend[SP_NMI] | pend[SP_INIT] | pend[SP_SIPI];
  assign fixed_ok = (hi_req > hi_svc) &&
                    (hi_req[VEC_W-1 -: PRIO_W] > tpr_q[VEC_W-1 -: PRIO_W]);
  assign irq_pending = spec_any | (core_ie & (pend[SP_EXT] | fixed_ok));

  always_comb begin
    kind       = K_NONE;
    pick       = '0;
    sel_vector = '0;
    if (pend[SP_SMI]) begin
      kind = K_SMI;     pick[SP_SMI]  = 1'b1; sel_vector = pvec[SP_SMI];
    end else if (pend[SP_NMI]) begin
      kind = K_NMI;     pick[SP_NMI]  = 1'b1; sel_vector = pvec[SP_NMI];
    end else if (pend[SP_INIT]) begin
      kind = K_INIT;    pick[SP_INIT] = 1'b1; sel_vector = pvec[SP_INIT];
    end else if (pend[SP_SIPI]) begin
      kind = K_STARTUP; pick[SP_SIPI] = 1'b1; sel_vector = pvec[SP_SIPI];
    end else if (core_ie && pend[SP_EXT]) begin
      kind = K_EXT;     pick[SP_EXT]  = 1'b1; sel_vector = pvec[SP_EXT];
    end else if (core_ie && fixed_ok) begin
      kind = K_FIXED;   sel_vector = hi_req;
    end
  end

  assign take_ack    = ack & irq_pending;
  assign clr         = take_ack ? pick : '0;
  assign move_en     = take_ack && (kind == K_FIXED);
  assign sel_kind    = kind;
  assign top_req_vec = hi_req;
  assign top_svc_vec = hi_svc;
  assign tpr_value   = tpr_q;

  // R5
  special_forces_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_any |-> irq_pending);

  // R7
  fixed_above_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_kind == K_FIXED) |-> (top_req_vec > top_svc_vec));

  // R7
  none_iff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_kind == K_NONE) == !irq_pending);

  // R8
  idle_ack_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_pending && !msg_valid && !eoi) |=>
      ($stable(top_req_vec) && $stable(top_svc_vec) && $stable(pend)));

endmodule

// File: tb/irq_accept_unit_tb_top.sv
`timescale 1ns/1ps
module irq_accept_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid, msg_level, core_ie, tpr_we, eoi, ack;
  logic [2:0] msg_mode;
  logic [7:0] msg_vector, tpr_wdata;
  logic       irq_pending, top_req_level;
  logic [2:0] sel_kind;
  logic [7:0] sel_vector, top_req_vec, top_svc_vec, tpr_value;
  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_accept_unit dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_mode(msg_mode),
    .msg_vector(msg_vector), .msg_level(msg_level), .core_ie(core_ie),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .eoi(eoi), .ack(ack),
    .irq_pending(irq_pending), .sel_kind(sel_kind), .sel_vector(sel_vector),
    .top_req_level(top_req_level), .top_req_vec(top_req_vec),
    .top_svc_vec(top_svc_vec), .tpr_value(tpr_value)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [7:0] v, input logic l);
    @(negedge clk);
    msg_valid = 1'b1; msg_mode = m; msg_vector = v; msg_level = l;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic set_tpr(input logic [7:0] v);
    @(negedge clk); tpr_we = 1'b1; tpr_wdata = v;
    @(negedge clk); tpr_we = 1'b0;
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk); core_ie = v; #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; msg_valid = 0; msg_mode = 0; msg_vector = 0; msg_level = 0;
    core_ie = 0; tpr_we = 0; tpr_wdata = 0; eoi = 0; ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", irq_pending, 0);
    chk("R1 kind", sel_kind, 0);
    chk("R1 vector", sel_vector, 0);
    chk("R1 top_req", top_req_vec, 0);
    chk("R1 top_svc", top_svc_vec, 0);
    chk("R1 tpr", tpr_value, 0);
    set_ie(1'b1);
    chk("R1 empty with ie", irq_pending, 0);
  endtask

  task automatic t_fixed_accept();
    send(3'd0, 8'h45, 1'b0);
    chk("R2 pending", irq_pending, 1);
    chk("R7 kind fixed", sel_kind, 6);
    chk("R7 vector", sel_vector, 8'h45);
    chk("R2 edge", top_req_level, 0);
    send(3'd1, 8'h45, 1'b1);
    chk("R2 trigger kept", top_req_level, 0);
    send(3'd0, 8'h62, 1'b1);
    chk("R2 top_req", top_req_vec, 8'h62);
    chk("R2 level", top_req_level, 1);
  endtask

  task automatic t_tpr_gate();
    set_tpr(8'h60);
    chk("R11 tpr value", tpr_value, 8'h60);
    chk("R11 equal class blocks", irq_pending, 0);
    set_tpr(8'h5F);
    chk("R11 lower class passes", irq_pending, 1);
    set_ie(1'b0);
    chk("R6 ie off", irq_pending, 0);
    set_ie(1'b1);
    chk("R6 ie on", irq_pending, 1);
  endtask

  task automatic t_ack_eoi();
    do_ack();
    chk("R9 svc", top_svc_vec, 8'h62);
    chk("R9 req", top_req_vec, 8'h45);
    chk("R6 below service", irq_pending, 0);
    send(3'd0, 8'h80, 1'b0);
    chk("R6 above service", irq_pending, 1);
    chk("R7 vector 80", sel_vector, 8'h80);
    do_ack();
    chk("R9 svc 80", top_svc_vec, 8'h80);
    do_eoi();
    chk("R10 svc falls", top_svc_vec, 8'h62);
    do_eoi();
    chk("R10 svc empty", top_svc_vec, 0);
    chk("R11 class 4 gated", irq_pending, 0);
    set_tpr(8'h00);
    chk("R11 ungated", sel_vector, 8'h45);
    do_ack();
    chk("R9 req empty", top_req_vec, 0);
    chk("R9 svc 45", top_svc_vec, 8'h45);
    do_eoi();
    chk("R10 cleared", top_svc_vec, 0);
  endtask

  task automatic t_special_order();
    set_ie(1'b0);
    send(3'd7, 8'h20, 1'b0);
    chk("R6 ext masked", irq_pending, 0);
    send(3'd5, 8'h11, 1'b0);
    chk("R5 init unmasked", irq_pending, 1);
    chk("R7 init kind", sel_kind, 3);
    send(3'd4, 8'h02, 1'b0);
    send(3'd2, 8'h03, 1'b0);
    chk("R7 smi first", sel_kind, 1);
    chk("R7 smi vector", sel_vector, 8'h03);
    send(3'd4, 8'h09, 1'b0);
    do_ack();
    chk("R8 nmi next", sel_kind, 2);
    chk("R3 nmi vector kept", sel_vector, 8'h02);
    do_ack();
    chk("R8 init next", sel_vector, 8'h11);
    do_ack();
    chk("R8 only ext left", irq_pending, 0);
    set_ie(1'b1);
    chk("R6 ext kind", sel_kind, 5);
    send(3'd0, 8'hF0, 1'b0);
    chk("R7 ext over fixed", sel_vector, 8'h20);
    do_ack();
    chk("R7 fixed after ext", sel_kind, 6);
    do_ack();
    chk("R9 svc F0", top_svc_vec, 8'hF0);
    do_eoi();
  endtask

  task automatic t_startup_once();
    send(3'd6, 8'h9A, 1'b0);
    chk("R4 startup kind", sel_kind, 4);
    chk("R4 startup vector", sel_vector, 8'h9A);
    do_ack();
    chk("R4 acked", irq_pending, 0);
    send(3'd6, 8'h9B, 1'b0);
    chk("R4 second dropped", irq_pending, 0);
    send(3'd5, 8'h11, 1'b0);
    do_ack();
    send(3'd6, 8'h9C, 1'b0);
    chk("R4 after init", sel_vector, 8'h9C);
    do_ack();
    chk("R4 done", irq_pending, 0);
  endtask

  task automatic t_reserved_ignored();
    send(3'd3, 8'h70, 1'b1);
    chk("R3 reserved pending", irq_pending, 0);
    chk("R3 reserved req", top_req_vec, 0);
  endtask

  task automatic t_ack_idle();
    set_ie(1'b0);
    send(3'd0, 8'h90, 1'b0);
    do_ack();
    chk("R8 idle ack req", top_req_vec, 8'h90);
    chk("R8 idle ack svc", top_svc_vec, 0);
    set_ie(1'b1);
    chk("R8 still deliverable", sel_vector, 8'h90);
  endtask

  initial begin
    t_reset();
    t_fixed_accept();
    t_tpr_gate();
    t_ack_eoi();
    t_special_order();
    t_startup_once();
    t_reserved_ignored();
    t_ack_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule